// File: doc/BRIEF.md
# Shifted-Immediate Add/Subtract Unit

This unit performs the add and subtract operations of a 64-bit core that take an immediate operand. The immediate is a 12-bit unsigned value. A shift select can move it left by twelve places before use. The operation runs on the full 64-bit width or on the low 32 bits, and it can update the NZCV condition flags.

Register index 31 has two meanings, and the caller tells the unit which operand names it. As a source it always reads the stack pointer. As a destination it is the stack pointer for operations that leave the flags alone. For flag-setting operations it is the zero register, so the result is discarded. That is how compare and compare-negative are formed.

All results are registered. They appear on the clock edge that follows a valid input strobe, together with write enables that steer the result either to the general register file or to the stack pointer.

Top module: `addsub_imm_unit`

## Requirements
- R1: The immediate operand equals `imm_i` zero-extended, shifted left by 12 bit positions when `shift_i` is 1 and left unshifted when it is 0.
- R2: With `sub_i`=0 the result is source plus immediate; with `sub_i`=1 it is source minus immediate; both wrap modulo 2 to the power of the selected width.
- R3: When `src_r31_i` is 1 the source is `sp_val_i`, otherwise `rn_val_i`, for flag-setting and non-flag-setting operations alike.
- R4: For an operation with `set_flags_i`=0, a destination of index 31 (`dst_r31_i`=1) raises `sp_we_o` and not `gpr_we_o`; any other destination raises `gpr_we_o` only.
- R5: For an operation with `set_flags_i`=1, a destination of index 31 raises neither write enable (zero register, as in compare and compare-negative); any other destination raises `gpr_we_o` only; `sp_we_o` is never raised.
- R6: With `wide_i`=0 only the low 32 bits of source and immediate are used and bits 63:32 of `result_o` are zero.
- R7: `flags_o` bit 3 is N (result sign bit), bit 2 is Z (result zero), bit 1 is C (unsigned carry out for add, no borrow for subtract) and bit 0 is V (signed overflow), all at the selected width.
- R8: `flags_o` changes only on the edge after a valid operation with `set_flags_i`=1, and otherwise holds its value.
- R9: `valid_o`, `result_o` and the write enables follow a `valid_i` strobe on the next rising edge; a cycle without `valid_i` gives `valid_o`, `gpr_we_o` and `sp_we_o` low on the next edge.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| wide_i | input | 1 | 1 = 64-bit, 0 = 32-bit |
| set_flags_i | input | 1 | Update NZCV; index 31 destination becomes the zero register |
| shift_i | input | 1 | Shift the immediate left by 12 |
| imm_i | input | 12 | Unsigned immediate |
| rn_val_i | input | 64 | General source register value |
| sp_val_i | input | 64 | Stack pointer value |
| src_r31_i | input | 1 | Source index is 31 |
| dst_r31_i | input | 1 | Destination index is 31 |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result is valid this cycle |
| gpr_we_o | output | 1 | Write result to the general register |
| sp_we_o | output | 1 | Write result to the stack pointer |
| flags_o | output | 4 | Held NZCV flags {N,Z,C,V} |

## Verification
The bench builds the unit with its default parameters: 64-bit data, a 12-bit immediate and a 12-place shift. With these values both lanes are reachable. Wraparound and overflow at bit 31 and at bit 63 are driven directly, and the largest shifted immediate (0xFFF000) meets operands near both boundaries. A long randomized run mixes widths, shifts and both register-31 roles against a reference that uses wider signed and unsigned integer arithmetic.

// File: rtl/addsub_imm_pkg.sv
package addsub_imm_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/aimm_expand.sv
module aimm_expand #(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 12,
  parameter int IMM_SHIFT = 12
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             shift_i,
  output logic [XLEN-1:0]  aimm_o
);
  logic [XLEN-1:0] base;
  assign base   = {{(XLEN-IMM_W){1'b0}}, imm_i};
  assign aimm_o = shift_i ? (base << IMM_SHIFT) : base;
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import addsub_imm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] res_o,
  output nzcv_t           flags_o
);
  localparam int HALF = XLEN / 2;

  logic [1:0]      lane_c, lane_v, lane_n;
  logic [XLEN-1:0] lane_res [2];

  // lane 0: narrow width, lane 1: full width
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? HALF : XLEN;
    logic [LW-1:0]   a_l, b_l;
    logic [LW:0]     s;
    logic [XLEN-1:0] ext;

    assign a_l = a_i[LW-1:0];
    assign b_l = sub_i ? ~b_i[LW-1:0] : b_i[LW-1:0];
    assign s   = {1'b0, a_l} + {1'b0, b_l} + {{LW{1'b0}}, sub_i};

    always_comb begin
      ext         = '0;
      ext[LW-1:0] = s[LW-1:0];
    end

    assign lane_res[g] = ext;
    assign lane_c[g]   = s[LW];
    assign lane_n[g]   = s[LW-1];
    assign lane_v[g]   = (a_l[LW-1] == b_l[LW-1]) && (s[LW-1] != a_l[LW-1]);
  end

  assign res_o     = lane_res[wide_i];
  assign flags_o.n = lane_n[wide_i];
  assign flags_o.z = (res_o == '0);
  assign flags_o.c = lane_c[wide_i];
  assign flags_o.v = lane_v[wide_i];
endmodule

// File: rtl/dest_router.sv
module dest_router (
  input  logic valid_i,
  input  logic set_flags_i,
  input  logic dst_r31_i,
  output logic gpr_we_o,
  output logic sp_we_o,
  output logic flag_we_o
);
  // index 31: stack pointer without flags, zero register with flags
  assign gpr_we_o  = valid_i && !dst_r31_i;
  assign sp_we_o   = valid_i && dst_r31_i && !set_flags_i;
  assign flag_we_o = valid_i && set_flags_i;
endmodule

// File: rtl/addsub_imm_unit.sv
module addsub_imm_unit
  import addsub_imm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 12,
  parameter int IMM_SHIFT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sub_i,
  input  logic             wide_i,
  input  logic             set_flags_i,
  input  logic             shift_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  rn_val_i,
  input  logic [XLEN-1:0]  sp_val_i,
  input  logic             src_r31_i,
  input  logic             dst_r31_i,
  output logic [XLEN-1:0]  result_o,
  output logic             valid_o,
  output logic             gpr_we_o,
  output logic             sp_we_o,
  output logic [3:0]       flags_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src, aimm, res_d;
  nzcv_t           flags_d, flags_q;
  logic            gpr_we_d, sp_we_d, flag_we_d;

  assign src = src_r31_i ? sp_val_i : rn_val_i;

  aimm_expand #(.XLEN(XLEN), .IMM_W(IMM_W), .IMM_SHIFT(IMM_SHIFT)) u_aimm (
    .imm_i  (imm_i),
    .shift_i(shift_i),
    .aimm_o (aimm)
  );

  addsub_core #(.XLEN(XLEN)) u_core (
    .a_i    (src),
    .b_i    (aimm),
    .sub_i  (sub_i),
    .wide_i (wide_i),
    .res_o  (res_d),
    .flags_o(flags_d)
  );

  dest_router u_route (
    .valid_i    (valid_i),
    .set_flags_i(set_flags_i),
    .dst_r31_i  (dst_r31_i),
    .gpr_we_o   (gpr_we_d),
    .sp_we_o    (sp_we_d),
    .flag_we_o  (flag_we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      gpr_we_o <= 1'b0;
      sp_we_o  <= 1'b0;
      flags_q  <= '0;
    end else begin
      valid_o  <= valid_i;
      gpr_we_o <= gpr_we_d;
      sp_we_o  <= sp_we_d;
      if (valid_i) result_o <= res_d;
      if (flag_we_d) flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  AST_FLAG_OP_NO_SP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_flags_i |=> !sp_we_o); // R5
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && set_flags_i) |=> $stable(flags_o)); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !gpr_we_o && !sp_we_o && !valid_o); // R9
  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> result_o[XLEN-1:HALF] == '0); // R6
  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gpr_we_o, sp_we_o})); // R4
  AST_SP_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !set_flags_i && dst_r31_i |=> sp_we_o && !gpr_we_o); // R4
endmodule

// File: tb/addsub_imm_unit_test.sv
module addsub_imm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sub = 1'b0, wide = 1'b0, sf = 1'b0, sh = 1'b0;
  logic [11:0] imm = '0;
  logic [63:0] rn = '0, sp = '0;
  logic        s31 = 1'b0, d31 = 1'b0;
  logic [63:0] result;
  logic        valid_o, gpr_we, sp_we;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_flags = 4'b0000;

  always #4 clk = ~clk; // 125 MHz

  addsub_imm_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sub_i(sub), .wide_i(wide),
    .set_flags_i(sf), .shift_i(sh), .imm_i(imm), .rn_val_i(rn), .sp_val_i(sp),
    .src_r31_i(s31), .dst_r31_i(d31), .result_o(result), .valid_o(valid_o),
    .gpr_we_o(gpr_we), .sp_we_o(sp_we), .flags_o(flags)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one operation: drive at a falling edge, check at the next falling edge
  task automatic do_op(bit op_sub, bit op_wide, bit op_sf, bit op_sh, logic [11:0] op_imm,
                       logic [63:0] op_rn, logic [63:0] op_sp, bit op_s31, bit op_d31,
                       string tag);
    logic [63:0] a, src, r;
    logic [64:0] wsum;
    logic signed [65:0] sv;
    logic n, z, c, v;
    @(negedge clk);
    valid = 1'b1; sub = op_sub; wide = op_wide; sf = op_sf; sh = op_sh; imm = op_imm;
    rn = op_rn; sp = op_sp; s31 = op_s31; d31 = op_d31;
    a   = op_sh ? (64'(op_imm) * 64'd4096) : 64'(op_imm);      // R1
    src = op_s31 ? op_sp : op_rn;                              // R3
    if (op_wide) begin
      r    = op_sub ? src - a : src + a;
      wsum = {1'b0, src} + {1'b0, a};
      c    = op_sub ? (src >= a) : wsum[64];
      sv   = op_sub ? $signed({{2{src[63]}}, src}) - $signed({{2{a[63]}}, a})
                    : $signed({{2{src[63]}}, src}) + $signed({{2{a[63]}}, a});
      v    = sv[64] != sv[63];
      n    = r[63];
    end else begin
      r    = {32'h0, op_sub ? src[31:0] - a[31:0] : src[31:0] + a[31:0]};  // R6
      wsum = {33'h0, src[31:0]} + {33'h0, a[31:0]};
      c    = op_sub ? (src[31:0] >= a[31:0]) : wsum[32];
      sv   = op_sub ? $signed({{34{src[31]}}, src[31:0]}) - $signed({{34{a[31]}}, a[31:0]})
                    : $signed({{34{src[31]}}, src[31:0]}) + $signed({{34{a[31]}}, a[31:0]});
      v    = sv[32] != sv[31];
      n    = r[31];
    end
    z = (r == 64'h0);
    if (op_sf) exp_flags = {n, z, c, v};                       // R7, R8
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " R2 result"}, result, r);
    chk("R9 valid_o", 64'(valid_o), 64'd1);
    chk("R4 R5 gpr_we_o", 64'(gpr_we), 64'(!op_d31));
    chk("R4 R5 sp_we_o", 64'(sp_we), 64'(op_d31 && !op_sf));
    chk("R7 R8 flags_o", 64'(flags), 64'(exp_flags));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result_o", result, 64'h0);
    chk("R10 valid_o", 64'(valid_o), 64'h0);
    chk("R10 we", 64'({gpr_we, sp_we}), 64'h0);
    chk("R10 flags_o", 64'(flags), 64'h0);
    rst_n = 1'b1;

    do_op(0, 1, 1, 0, 12'h005, 64'd10, 64'd0, 0, 0, "R2 add64");
    do_op(1, 1, 1, 0, 12'h00a, 64'd3, 64'd0, 0, 0, "R2 sub64 borrow");
    do_op(0, 1, 0, 1, 12'hfff, 64'h1, 64'd0, 0, 0, "R1 shift12");
    do_op(0, 1, 1, 0, 12'h001, 64'hffff_ffff_ffff_ffff, 64'd0, 0, 0, "R2 wrap64");
    do_op(0, 0, 1, 0, 12'h001, 64'h1234_5678_ffff_ffff, 64'd0, 0, 0, "R6 wrap32");
    do_op(0, 1, 1, 0, 12'h001, 64'h7fff_ffff_ffff_ffff, 64'd0, 0, 0, "R7 ovf64");
    do_op(0, 0, 1, 0, 12'h001, 64'h0000_0000_7fff_ffff, 64'd0, 0, 0, "R7 ovf32");
    do_op(1, 0, 1, 1, 12'h001, 64'hffff_ffff_8000_0000, 64'd0, 0, 0, "R7 sub ovf32");
    // R8: non-flag op leaves flags untouched
    do_op(1, 1, 0, 0, 12'h000, 64'h0, 64'd0, 0, 0, "R8 hold");
    // R3: source index 31 reads stack pointer; R4: no-flag dest 31 writes SP
    do_op(1, 1, 0, 0, 12'h010, 64'hdead, 64'h1000, 1, 1, "R3 R4 sp adjust");
    // R5: compare and compare-negative discard result
    do_op(1, 1, 1, 0, 12'h100, 64'h0, 64'h100, 1, 1, "R5 cmp");
    do_op(0, 0, 1, 1, 12'h800, 64'hffff_ffff_ff80_0000, 64'd0, 0, 1, "R5 cmn");

    // R9: idle cycle drops valid and write enables
    @(negedge clk);
    chk("R9 idle valid_o", 64'(valid_o), 64'h0);
    chk("R9 idle we", 64'({gpr_we, sp_we}), 64'h0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (i % 5 == 0) x = {x[63:33], 33'h0};
      if (i % 7 == 0) x = 64'hffff_ffff_ffff_ffff - 64'(i);
      do_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 12'($urandom),
            x, y, 1'($urandom), 1'($urandom), "R2 random");
    end

    finish_run();
  end
endmodule